// File: doc/BRIEF.md
# Check-Gated Commit and Rollback Unit

This unit works beside a simple in-order core whose finished instructions are checked by a separate monitoring co-processor. The core writes its own register file at commit, so later instructions can use a result at once. It also sends each finished instruction here once the instruction has been handed to the checker. The unit holds these unchecked instructions in arrival order. It also keeps a shadow copy of the register file that only ever holds values whose check has passed.

Each check result applies to the oldest pending instruction. A pass retires that instruction. Its register result, if any, goes into the shadow copy, and its buffered store, if any, is released to memory through the store-release port. A fail starts a rollback. The queue is emptied at once. The shadow copy is then streamed back into the core's register file, one register per cycle. After that comes a single cycle that flushes the store buffer and the pipeline and redirects fetch to the exception handler address. A sticky status bit records that a check failed. While the rollback runs, the unit reports itself busy and refuses new work.

Top module: `ckr_commit_gate`

## Requirements
- R1: While reset is held and right after it, the queue is empty and `busy`, `enq_stall`, `rel_valid`, `rst_wr_en`, `flush`, `redirect_valid`, `chk_fail_seen` and `chk_spurious` are all 0. Every shadow register holds 0.
- R2: A pass retires entries strictly in arrival order. In the cycle a pass is presented, `rel_valid` is 1 exactly when the oldest entry has `enq_has_st`=1, and `rel_st_idx` carries that entry's store-buffer index.
- R3: A pass on an entry with `enq_has_rd`=1 writes that entry's value into shadow register `enq_rd` at the clock edge. A shadow register that no passed entry has written keeps the value 0. A failed entry's value never reaches it.
- R4: An entry with neither `enq_has_rd` nor `enq_has_st` set only leaves the queue when its pass arrives. It gives no store release and no shadow write.
- R5: `enq_stall` is 1 when the queue holds DEPTH entries and no pass is presented, and a stalled enqueue is dropped. With a full queue, an enqueue and a pass in the same cycle are both accepted.
- R6: After a fail is presented at the edge of cycle T, `rst_wr_en` is 1 for NREGS cycles starting at T+1. In those cycles `rst_wr_idx` counts 0,1,…,NREGS-1 and `rst_wr_val` is the shadow register with that index.
- R7: In the cycle right after the last restore write, `flush` and `redirect_valid` are both 1 for exactly one cycle and `redirect_pc` equals HANDLER_PC. The queue is empty from the fail onward, so every entry pending at the fail is discarded.
- R8: `chk_fail_seen` becomes 1 at the edge where a fail is taken and stays 1 until reset.
- R9: `busy` is 1 from the cycle after a fail through the flush cycle. While busy, and in the fail cycle itself, `enq_stall` is 1 and enqueues are dropped. While busy, check results have no effect: no release, no error flag.
- R10: A check result presented while the queue is empty and the unit is not busy changes no state except that the sticky `chk_spurious` flag becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Core offers a finished instruction |
| enq_has_rd | input | 1 | Instruction writes a register |
| enq_rd | input | RAW | Destination register number |
| enq_rd_val | input | DW | Register write value |
| enq_has_st | input | 1 | Instruction owns a store-buffer entry |
| enq_st_idx | input | SIW | Store-buffer entry index |
| enq_stall | output | 1 | Enqueue refused this cycle |
| chk_valid | input | 1 | Checker presents a result for the oldest entry |
| chk_pass | input | 1 | 1 = pass, 0 = fail |
| rel_valid | output | 1 | Release the store at rel_st_idx to memory |
| rel_st_idx | output | SIW | Store-buffer index being released |
| rst_wr_en | output | 1 | Restore write into the core register file |
| rst_wr_idx | output | RAW | Register being restored |
| rst_wr_val | output | DW | Checked value to restore |
| flush | output | 1 | Flush store buffer and pipeline |
| redirect_valid | output | 1 | Inject a jump to the handler |
| redirect_pc | output | PCW | Handler address |
| busy | output | 1 | Rollback in progress |
| chk_fail_seen | output | 1 | Sticky: a check has failed |
| chk_spurious | output | 1 | Sticky: a result arrived with nothing pending |

## Verification
The assertions assume that the core never drives an enqueue or a check result while reset is low. They also assume that `enq_rd` always names a register below NREGS and that the checker sends at most one result per cycle. The bench drives every input at the falling edge from tasks. It uses only register numbers 0 to 7 with the default eight registers. It sends results while the queue is empty or the unit is busy only as deliberate cases, where the assertions expect no effect apart from the spurious flag.

// File: rtl/ckr_pkg.sv
package ckr_pkg;

  typedef enum logic [1:0] {
    CK_RUN     = 2'd0,
    CK_RESTORE = 2'd1,
    CK_FLUSH   = 2'd2
  } ck_state_e;

  // Circular pointer advance for a ring of the given size.
  function automatic logic [31:0] wrap_inc(logic [31:0] p, int unsigned depth);
    return (p + 32'd1 == depth) ? 32'd0 : p + 32'd1;
  endfunction

  // Occupancy after one cycle of push and pop.
  function automatic logic [31:0] occ_next(logic [31:0] occ, logic push, logic pop);
    return occ + {31'd0, push} - {31'd0, pop};
  endfunction

  // True on the final register of a restore sweep.
  function automatic logic sweep_last(logic [31:0] idx, int unsigned nregs);
    return idx == nregs - 1;
  endfunction

endpackage

// File: rtl/ckr_uiq.sv
module ckr_uiq #(
  parameter int DEPTH = 4,
  parameter int RAW   = 3,
  parameter int DW    = 16,
  parameter int SIW   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic           push_has_rd,
  input  logic [RAW-1:0] push_rd,
  input  logic [DW-1:0]  push_val,
  input  logic           push_has_st,
  input  logic [SIW-1:0] push_st,
  input  logic           pop,
  input  logic           clear,
  output logic           head_has_rd,
  output logic [RAW-1:0] head_rd,
  output logic [DW-1:0]  head_val,
  output logic           head_has_st,
  output logic [SIW-1:0] head_st,
  output logic           empty,
  output logic           full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = 1 + RAW + DW + 1 + SIW;

  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ;
  logic [EW-1:0] slot_bus [DEPTH];
  logic [EW-1:0] push_word, head_word;

  assign push_word = {push_has_rd, push_rd, push_val, push_has_st, push_st};

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [EW-1:0] slot_q;
    logic          slot_we;
    assign slot_we = push && (wr_ptr == PW'(g));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q <= push_word;
    end
    assign slot_bus[g] = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= PW'(ckr_pkg::wrap_inc(32'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PW'(ckr_pkg::wrap_inc(32'(rd_ptr), DEPTH));
      occ <= CW'(ckr_pkg::occ_next(32'(occ), push, pop));
    end
  end

  assign head_word   = slot_bus[rd_ptr];
  assign head_has_rd = head_word[EW-1];
  assign head_rd     = head_word[EW-2 -: RAW];
  assign head_val    = head_word[SIW+1 +: DW];
  assign head_has_st = head_word[SIW];
  assign head_st     = head_word[SIW-1:0];
  assign empty       = (occ == '0);
  assign full        = (occ == CW'(DEPTH));
  assign count       = occ;

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> empty);

endmodule

// File: rtl/ckr_brf.sv
module ckr_brf #(
  parameter int NREGS = 8,
  parameter int RAW   = 3,
  parameter int DW    = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_idx,
  input  logic [DW-1:0]  wr_val,
  input  logic [RAW-1:0] rd_idx,
  output logic [DW-1:0]  rd_val
);
  logic [DW-1:0] bank [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [DW-1:0] reg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                reg_q <= '0;
      else if (wr_en && (wr_idx == RAW'(g)))     reg_q <= wr_val;
    end
    assign bank[g] = reg_q;
  end

  assign rd_val = bank[rd_idx];

  p_wr_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_idx) < NREGS));

endmodule

// File: rtl/ckr_ctl.sv
module ckr_ctl #(
  parameter int NREGS = 8,
  parameter int RAW   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fail_now,
  output logic           busy,
  output logic           restoring,
  output logic           flushing,
  output logic [RAW-1:0] sweep_idx
);
  import ckr_pkg::*;

  ck_state_e     state_q;
  logic [RAW-1:0] idx_q;
  logic           at_last;

  assign at_last = sweep_last(32'(idx_q), NREGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CK_RUN;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        CK_RUN: begin
          if (fail_now) begin
            state_q <= CK_RESTORE;
            idx_q   <= '0;
          end
        end
        CK_RESTORE: begin
          if (at_last) state_q <= CK_FLUSH;
          else         idx_q   <= idx_q + RAW'(1);
        end
        CK_FLUSH: state_q <= CK_RUN;
        default:  state_q <= CK_RUN;
      endcase
    end
  end

  assign busy      = (state_q != CK_RUN);
  assign restoring = (state_q == CK_RESTORE);
  assign flushing  = (state_q == CK_FLUSH);
  assign sweep_idx = idx_q;

  p_sweep_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restoring) |-> (sweep_idx == '0));
  p_sweep_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (restoring && $past(restoring)) |-> (sweep_idx == RAW'($past(sweep_idx) + RAW'(1))));
  p_flush_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(restoring) |-> flushing);
  p_flush_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |=> !busy);
  p_fail_only_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_now |-> !busy);

endmodule

// File: rtl/ckr_commit_gate.sv
module ckr_commit_gate #(
  parameter int          NREGS      = 8,
  parameter int          DEPTH      = 4,
  parameter int          DW         = 16,
  parameter int          SIW        = 3,
  parameter int          PCW        = 32,
  parameter logic [31:0] HANDLER_PC = 32'h0000_0100,
  localparam int         RAW        = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enq_valid,
  input  logic           enq_has_rd,
  input  logic [RAW-1:0] enq_rd,
  input  logic [DW-1:0]  enq_rd_val,
  input  logic           enq_has_st,
  input  logic [SIW-1:0] enq_st_idx,
  output logic           enq_stall,
  input  logic           chk_valid,
  input  logic           chk_pass,
  output logic           rel_valid,
  output logic [SIW-1:0] rel_st_idx,
  output logic           rst_wr_en,
  output logic [RAW-1:0] rst_wr_idx,
  output logic [DW-1:0]  rst_wr_val,
  output logic           flush,
  output logic           redirect_valid,
  output logic [PCW-1:0] redirect_pc,
  output logic           busy,
  output logic           chk_fail_seen,
  output logic           chk_spurious
);
  localparam int CW = $clog2(DEPTH + 1);

  // Named internal events
  logic           q_empty, q_full;
  logic [CW-1:0]  q_count;
  logic           h_has_rd, h_has_st;
  logic [RAW-1:0] h_rd;
  logic [DW-1:0]  h_val;
  logic [SIW-1:0] h_st;
  logic           ev_retire, ev_fail, ev_spurious, ev_push;
  logic           ctl_busy, ctl_restoring, ctl_flushing;
  logic [RAW-1:0] ctl_idx;
  logic [DW-1:0]  shadow_rd;

  assign ev_retire   = chk_valid &&  chk_pass && !q_empty && !ctl_busy;
  assign ev_fail     = chk_valid && !chk_pass && !q_empty && !ctl_busy;
  assign ev_spurious = chk_valid &&  q_empty  && !ctl_busy;
  assign enq_stall   = ctl_busy || ev_fail || (q_full && !ev_retire);
  assign ev_push     = enq_valid && !enq_stall;

  ckr_uiq #(.DEPTH(DEPTH), .RAW(RAW), .DW(DW), .SIW(SIW)) u_queue (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (ev_push),
    .push_has_rd (enq_has_rd),
    .push_rd     (enq_rd),
    .push_val    (enq_rd_val),
    .push_has_st (enq_has_st),
    .push_st     (enq_st_idx),
    .pop         (ev_retire),
    .clear       (ev_fail),
    .head_has_rd (h_has_rd),
    .head_rd     (h_rd),
    .head_val    (h_val),
    .head_has_st (h_has_st),
    .head_st     (h_st),
    .empty       (q_empty),
    .full        (q_full),
    .count       (q_count)
  );

  ckr_brf #(.NREGS(NREGS), .RAW(RAW), .DW(DW)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ev_retire && h_has_rd),
    .wr_idx (h_rd),
    .wr_val (h_val),
    .rd_idx (ctl_idx),
    .rd_val (shadow_rd)
  );

  ckr_ctl #(.NREGS(NREGS), .RAW(RAW)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fail_now  (ev_fail),
    .busy      (ctl_busy),
    .restoring (ctl_restoring),
    .flushing  (ctl_flushing),
    .sweep_idx (ctl_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_fail_seen <= 1'b0;
      chk_spurious  <= 1'b0;
    end else begin
      if (ev_fail)     chk_fail_seen <= 1'b1;
      if (ev_spurious) chk_spurious  <= 1'b1;
    end
  end

  assign rel_valid      = ev_retire && h_has_st;
  assign rel_st_idx     = h_st;
  assign rst_wr_en      = ctl_restoring;
  assign rst_wr_idx     = ctl_idx;
  assign rst_wr_val     = shadow_rd;
  assign flush          = ctl_flushing;
  assign redirect_valid = ctl_flushing;
  assign redirect_pc    = PCW'(HANDLER_PC);
  assign busy           = ctl_busy;

  p_release_has_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (q_count != '0));
  p_retire_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_retire && !ev_push) |=> (q_count == CW'($past(q_count) - CW'(1))));
  p_busy_stalls_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (enq_stall && !rel_valid));
  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fail_seen |=> chk_fail_seen);
  p_fail_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> (chk_fail_seen && busy));
  p_empty_result_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && q_empty && !busy) |=> (chk_spurious && q_empty));
  p_flush_queue_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> q_empty);

endmodule

// File: tb/tb_ckr_commit_gate.sv
`timescale 1ns/1ps
module tb_ckr_commit_gate;
  localparam int NREGS = 8;
  localparam int DEPTH = 4;
  localparam int DW    = 16;
  localparam int SIW   = 3;
  localparam int PCW   = 32;
  localparam logic [31:0] HPC = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid = 0, enq_has_rd = 0, enq_has_st = 0;
  logic [2:0] enq_rd = 0;
  logic [DW-1:0] enq_rd_val = 0;
  logic [SIW-1:0] enq_st_idx = 0;
  logic chk_valid = 0, chk_pass = 0;
  logic enq_stall, rel_valid, rst_wr_en, flush, redirect_valid, busy;
  logic chk_fail_seen, chk_spurious;
  logic [SIW-1:0] rel_st_idx;
  logic [2:0] rst_wr_idx;
  logic [DW-1:0] rst_wr_val;
  logic [PCW-1:0] redirect_pc;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] shadow_m [NREGS];

  always #10 clk = ~clk;

  ckr_commit_gate #(.NREGS(NREGS), .DEPTH(DEPTH), .DW(DW), .SIW(SIW),
                    .PCW(PCW), .HANDLER_PC(HPC)) dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_has_rd(enq_has_rd),
    .enq_rd(enq_rd), .enq_rd_val(enq_rd_val), .enq_has_st(enq_has_st),
    .enq_st_idx(enq_st_idx), .enq_stall(enq_stall), .chk_valid(chk_valid),
    .chk_pass(chk_pass), .rel_valid(rel_valid), .rel_st_idx(rel_st_idx),
    .rst_wr_en(rst_wr_en), .rst_wr_idx(rst_wr_idx), .rst_wr_val(rst_wr_val),
    .flush(flush), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .busy(busy), .chk_fail_seen(chk_fail_seen), .chk_spurious(chk_spurious));

  typedef struct packed {
    logic ev; logic hr; logic [2:0] rd; logic [15:0] val; logic hs; logic [2:0] st;
    logic cv; logic cp; logic x_stall; logic x_rel; logic [2:0] x_idx;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{1'b1,1'b1,3'd1,16'h1111,1'b1,3'd5, 1'b0,1'b0, 1'b0,1'b0,3'd0},
    '{1'b1,1'b1,3'd2,16'h2222,1'b0,3'd0, 1'b0,1'b0, 1'b0,1'b0,3'd0},
    '{1'b1,1'b0,3'd0,16'h0000,1'b0,3'd0, 1'b0,1'b0, 1'b0,1'b0,3'd0},
    '{1'b1,1'b1,3'd3,16'h3333,1'b1,3'd2, 1'b0,1'b0, 1'b0,1'b0,3'd0},
    '{1'b1,1'b1,3'd7,16'h7777,1'b1,3'd7, 1'b0,1'b0, 1'b1,1'b0,3'd0},
    '{1'b1,1'b1,3'd4,16'h4444,1'b1,3'd6, 1'b1,1'b1, 1'b0,1'b1,3'd5},
    '{1'b0,1'b0,3'd0,16'h0000,1'b0,3'd0, 1'b1,1'b1, 1'b0,1'b0,3'd0},
    '{1'b0,1'b0,3'd0,16'h0000,1'b0,3'd0, 1'b1,1'b1, 1'b0,1'b0,3'd0},
    '{1'b0,1'b0,3'd0,16'h0000,1'b0,3'd0, 1'b1,1'b1, 1'b0,1'b1,3'd2},
    '{1'b0,1'b0,3'd0,16'h0000,1'b0,3'd0, 1'b1,1'b1, 1'b0,1'b1,3'd6},
    '{1'b0,1'b0,3'd0,16'h0000,1'b0,3'd0, 1'b1,1'b1, 1'b0,1'b0,3'd0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic ev, logic hr, logic [2:0] rd, logic [15:0] val,
                       logic hs, logic [2:0] st, logic cv, logic cp);
    @(negedge clk);
    enq_valid = ev; enq_has_rd = hr; enq_rd = rd; enq_rd_val = val;
    enq_has_st = hs; enq_st_idx = st; chk_valid = cv; chk_pass = cp;
    #5;
  endtask

  // Bench-side queue model
  logic        qm_hr [8];
  logic [2:0]  qm_rd [8];
  logic [15:0] qm_val [8];
  int qm_head = 0, qm_n = 0;

  initial begin
    #(20 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREGS; i++) shadow_m[i] = '0;
    // R1: reset state
    repeat (3) @(negedge clk);
    #5;
    check("R1 busy", busy, 0);
    check("R1 stall", enq_stall, 0);
    check("R1 rel", rel_valid, 0);
    check("R1 restore", rst_wr_en, 0);
    check("R1 flush", {flush, redirect_valid}, 0);
    check("R1 flags", {chk_fail_seen, chk_spurious}, 0);
    @(negedge clk); rst_n = 1'b1;

    // Vector walk: R2, R3, R4, R5, R10
    for (int v = 0; v < NV; v++) begin
      drive(VT[v].ev, VT[v].hr, VT[v].rd, VT[v].val, VT[v].hs, VT[v].st, VT[v].cv, VT[v].cp);
      check($sformatf("R5 stall vec%0d", v), enq_stall, VT[v].x_stall);
      check($sformatf("R2 R4 release vec%0d", v), rel_valid, VT[v].x_rel);
      if (VT[v].x_rel) check($sformatf("R2 index vec%0d", v), rel_st_idx, VT[v].x_idx);
      if (VT[v].cv && VT[v].cp && qm_n > 0) begin
        if (qm_hr[qm_head]) shadow_m[qm_rd[qm_head]] = qm_val[qm_head];
        qm_head = (qm_head + 1) % 8; qm_n--;
      end
      if (VT[v].ev && !VT[v].x_stall) begin
        qm_hr[(qm_head + qm_n) % 8] = VT[v].hr;
        qm_rd[(qm_head + qm_n) % 8] = VT[v].rd;
        qm_val[(qm_head + qm_n) % 8] = VT[v].val;
        qm_n++;
      end
    end

    // R10: result on an empty queue raised the flag only
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    check("R10 spurious flag", chk_spurious, 1);
    check("R10 no fail", chk_fail_seen, 0);
    check("R10 not busy", busy, 0);

    // Rollback scenario
    drive(1, 1, 3'd5, 16'h5555, 1, 3'd1, 0, 0);
    drive(1, 1, 3'd1, 16'hBEEF, 0, 3'd0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 1, 1);
    check("R2 release F", {rel_valid, rel_st_idx}, {1'b1, 3'd1});
    shadow_m[5] = 16'h5555;
    drive(1, 1, 3'd6, 16'hAAAA, 1, 3'd4, 1, 0);
    check("R9 stall on fail", enq_stall, 1);
    check("R9 no release on fail", rel_valid, 0);
    for (int k = 0; k < NREGS; k++) begin
      drive(1, 1, 3'd7, 16'h9999, 1, 3'd3, 1, 1);
      check($sformatf("R6 restore en %0d", k), rst_wr_en, 1);
      check($sformatf("R6 restore idx %0d", k), rst_wr_idx, k);
      check($sformatf("R6 R3 restore val %0d", k), rst_wr_val, shadow_m[k]);
      check($sformatf("R9 busy %0d", k), {busy, enq_stall, rel_valid}, 3'b110);
      check($sformatf("R7 no early flush %0d", k), flush, 0);
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    check("R7 flush", {flush, redirect_valid, rst_wr_en}, 3'b110);
    check("R7 redirect pc", redirect_pc, HPC);
    check("R9 busy in flush", busy, 1);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    check("R7 single flush", {flush, redirect_valid, busy}, 0);
    check("R8 fail sticky", chk_fail_seen, 1);

    // R7, R9: queue empty after rollback; nothing dropped in crept in
    drive(1, 0, 0, 0, 1, 3'd3, 0, 0);
    check("R7 accept 1", enq_stall, 0);
    drive(1, 0, 0, 0, 0, 3'd0, 0, 0);
    check("R7 accept 2", enq_stall, 0);
    drive(1, 0, 0, 0, 0, 3'd0, 0, 0);
    check("R7 accept 3", enq_stall, 0);
    drive(1, 0, 0, 0, 0, 3'd0, 0, 0);
    check("R7 accept 4", enq_stall, 0);
    drive(1, 0, 0, 0, 0, 3'd0, 0, 0);
    check("R5 R9 full after four", enq_stall, 1);
    drive(0, 0, 0, 0, 0, 0, 1, 1);
    check("R2 oldest after rollback", {rel_valid, rel_st_idx}, {1'b1, 3'd3});
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    check("R8 still set", chk_fail_seen, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule